// File: doc/BRIEF.md
# Atomic 16-bit Register Byte Bridge

This block sits between an 8-bit register bus and two 16-bit timer registers: a capture register and a compare/TOP register. Every 16-bit value occupies two byte addresses. The bus can reach any 16-bit value only one byte at a time. To keep a 16-bit value consistent, the bridge routes both halves through a single shared high-byte holding register.

A read of a low byte returns that byte. In the same cycle it also freezes the matching high byte into the holding register, and a later read of any high-byte address returns the holding register. A write to a high-byte address only loads the holding register. A later write to a low-byte address then commits both halves to the target register in one edge and pulses that register's write-enable towards the timer core.

The capture register takes new values from the timer core whenever a capture strobe arrives. It takes bus writes only while the core reports a mode that uses the capture register as its counting TOP value. In that mode, capture strobes are ignored.

Top module: `tmr16_byte_bridge`

## Requirements
- R1: After reset, both 16-bit registers, the holding register, the read data and both write-enable pulses are zero.
- R2: A read strobe at a low-byte address (0 = capture low, 2 = compare low) returns that register's bits [7:0] on `bus_rdata` in the next cycle. In the same edge, it copies bits [15:8] of that register into the holding register.
- R3: A read strobe at a high-byte address (1 = capture high, 3 = compare high) returns the holding register. It does not return the register's current high byte, even when that byte has changed since the low-byte read.
- R4: A write strobe at a high-byte address (1 or 3) loads `bus_wdata` into the holding register and leaves both 16-bit registers unchanged.
- R5: A write strobe at a low-byte address sets the target register to {holding register, `bus_wdata`} at that clock edge. The target's write-enable output is high for exactly the following cycle.
- R6: While `top_mode` is 0, a write to address 0 leaves the capture register unchanged and raises no `cap_we`.
- R7: While `top_mode` is 0, `cap_strobe` loads `cap_in` into the capture register at the clock edge. While `top_mode` is 1, `cap_strobe` has no effect.
- R8: One holding register serves both 16-bit registers. An access to the other register between a high-byte write and its low-byte commit changes the high byte that gets committed.
- R9: Reads of addresses 1 and 3 return the same holding register value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Byte address: 0 cap low, 1 cap high, 2 cmp low, 3 cmp high |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid the cycle after the read strobe |
| top_mode | input | 1 | Core mode uses the capture register as TOP |
| cap_strobe | input | 1 | Capture event from the core |
| cap_in | input | 16 | Live value to capture |
| cap_q | output | 16 | Capture register value |
| cmp_q | output | 16 | Compare/TOP register value |
| cap_we | output | 1 | Pulse: bus committed a capture register write |
| cmp_we | output | 1 | Pulse: bus committed a compare register write |

## Verification
Full 16-bit writes and reads of the compare register in the correct byte order show that the halves are assembled and split correctly. In the correct read order, a capture that lands between the low-byte and high-byte reads tells the frozen high byte apart from the live one. Capture-register writes and strobes are tried in both mode settings, which separates the mode gate from the commit path. An interleaved access to the compare register in the middle of a capture-register write shows that the holding register is shared rather than kept separately for each register.

// File: rtl/tmr16_byte_bridge.sv
module tmr16_byte_bridge (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  bus_addr,
  input  logic        bus_rd,
  input  logic        bus_wr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic        top_mode,
  input  logic        cap_strobe,
  input  logic [15:0] cap_in,
  output logic [15:0] cap_q,
  output logic [15:0] cmp_q,
  output logic        cap_we,
  output logic        cmp_we
);

  logic [7:0] hold_q;

  wire wr_hi    = bus_wr & bus_addr[0];
  wire wr_cap   = bus_wr & (bus_addr == 2'd0) & top_mode;
  wire wr_cmp   = bus_wr & (bus_addr == 2'd2);
  wire cap_take = cap_strobe & ~top_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q    <= '0;
      bus_rdata <= '0;
      cap_q     <= '0;
      cmp_q     <= '0;
      cap_we    <= 1'b0;
      cmp_we    <= 1'b0;
    end else begin
      cap_we <= wr_cap;
      cmp_we <= wr_cmp;
      if (bus_rd) begin
        case (bus_addr)
          2'd0: begin bus_rdata <= cap_q[7:0]; hold_q <= cap_q[15:8]; end
          2'd2: begin bus_rdata <= cmp_q[7:0]; hold_q <= cmp_q[15:8]; end
          default: bus_rdata <= hold_q;
        endcase
      end
      if (wr_hi)    hold_q <= bus_wdata;
      if (cap_take) cap_q  <= cap_in;
      if (wr_cap)   cap_q  <= {hold_q, bus_wdata};
      if (wr_cmp)   cmp_q  <= {hold_q, bus_wdata};
    end
  end

  p_hi_wr_no_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[0] && !cap_strobe) |=> ($stable(cap_q) && $stable(cmp_q)));

  p_cmp_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd2) |=> (cmp_q == {$past(hold_q), $past(bus_wdata)} && cmp_we));

  p_cap_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0 && !top_mode && !cap_strobe) |=> ($stable(cap_q) && !cap_we));

  p_capture_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_strobe && top_mode && !(bus_wr && bus_addr == 2'd0)) |=> $stable(cap_q));

  p_hi_read_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr[0]) |=> (bus_rdata == $past(hold_q)));

  p_we_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cap_we, cmp_we}));

endmodule

// File: tb/tmr16_byte_bridge_test.sv
module tmr16_byte_bridge_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  bus_addr = 0;
  logic        bus_rd = 0, bus_wr = 0;
  logic [7:0]  bus_wdata = 0;
  logic [7:0]  bus_rdata;
  logic        top_mode = 0, cap_strobe = 0;
  logic [15:0] cap_in = 0;
  logic [15:0] cap_q, cmp_q;
  logic        cap_we, cmp_we;
  int          n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  tmr16_byte_bridge uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .top_mode(top_mode),
    .cap_strobe(cap_strobe), .cap_in(cap_in), .cap_q(cap_q), .cmp_q(cmp_q),
    .cap_we(cap_we), .cmp_we(cmp_we));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic capture(input logic [15:0] v);
    @(negedge clk); cap_in = v; cap_strobe = 1;
    @(negedge clk); cap_strobe = 0;
  endtask

  task automatic t_reset;
    chk("R1 cap_q", cap_q, 16'h0);
    chk("R1 cmp_q", cmp_q, 16'h0);
    chk("R1 we", {14'b0, cap_we, cmp_we}, 16'h0);
    rd(2'd1);
    chk("R1 hold", {8'h0, bus_rdata}, 16'h0);
  endtask

  task automatic t_cmp_write;
    wr(2'd3, 8'hAB);
    chk("R4 cmp_q after hi write", cmp_q, 16'h0);
    chk("R4 no we", {15'b0, cmp_we}, 16'h0);
    wr(2'd2, 8'hCD);
    chk("R5 cmp_q commit", cmp_q, 16'hABCD);
    chk("R5 cmp_we pulse", {15'b0, cmp_we}, 16'h1);
    @(negedge clk);
    chk("R5 cmp_we one cycle", {15'b0, cmp_we}, 16'h0);
  endtask

  task automatic t_read_order;
    rd(2'd2);
    chk("R2 cmp low", {8'h0, bus_rdata}, 16'h00CD);
    rd(2'd3);
    chk("R2 cmp high via hold", {8'h0, bus_rdata}, 16'h00AB);
  endtask

  task automatic t_cap_locked;
    top_mode = 0;
    wr(2'd1, 8'h12);
    wr(2'd0, 8'h34);
    chk("R6 cap unchanged", cap_q, 16'h0);
    chk("R6 no cap_we", {15'b0, cap_we}, 16'h0);
  endtask

  task automatic t_capture;
    capture(16'h5678);
    chk("R7 capture loads", cap_q, 16'h5678);
    rd(2'd0);
    chk("R2 cap low", {8'h0, bus_rdata}, 16'h0078);
    capture(16'h9ABC);
    rd(2'd1);
    chk("R3 frozen high byte", {8'h0, bus_rdata}, 16'h0056);
    chk("R7 second capture", cap_q, 16'h9ABC);
  endtask

  task automatic t_top_mode;
    top_mode = 1;
    capture(16'h1111);
    chk("R7 capture ignored in top mode", cap_q, 16'h9ABC);
    wr(2'd1, 8'hDE);
    wr(2'd0, 8'hAD);
    chk("R5 cap commit", cap_q, 16'hDEAD);
    chk("R5 cap_we pulse", {15'b0, cap_we}, 16'h1);
    chk("R5 cmp untouched", cmp_q, 16'hABCD);
  endtask

  task automatic t_shared;
    wr(2'd1, 8'h77);
    rd(2'd2);
    rd(2'd1);
    chk("R9 hold via addr 1", {8'h0, bus_rdata}, 16'h00AB);
    rd(2'd3);
    chk("R9 hold via addr 3", {8'h0, bus_rdata}, 16'h00AB);
    wr(2'd0, 8'h01);
    chk("R8 interleave corrupts high", cap_q, 16'hAB01);
    wr(2'd3, 8'h42);
    wr(2'd0, 8'h99);
    chk("R8 cmp hi feeds cap", cap_q, 16'h4299);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_cmp_write;
    t_read_order;
    t_cap_locked;
    t_capture;
    t_top_mode;
    t_shared;
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule